// File: doc/BRIEF.md
# Triple-Redundant Controller Guard with Disagreement Alarm

This block wraps three identical copies of a small sequential controller, a step counter of the kind that walks addresses during a memory scrub. All three copies see the same inputs. Their state is combined bit by bit through a two-out-of-three majority, and the voted value is presented as the block's registered output. A copy that has been corrupted by an upset is therefore masked at the output.

Masking alone would let a second upset land on top of the first. To prevent that, the block compares the full state of the three copies on every cycle. When any copy disagrees with the others, it raises an alarm and reports which copy is the odd one. On the same clock edge it reloads every copy with the voted value, so the damaged copy is resynchronized at once and does not wait for a later maintenance pass.

If all three copies disagree, no majority is trustworthy. In that case a sticky fatal flag is set and the repair request stays high until reset. An upset input lets each copy's state be disturbed bit by bit. Test logic or a fault-injection engine uses it to provoke single-event effects.

Top module: `tmr_scrub_guard`

## Requirements
- R1: `data_o` is registered. After each clock edge it holds the bitwise two-out-of-three majority of the three copies' states as they stood just before that edge.
- R2: While the copies agree, each copy increments by one on every edge where `adv_i` is 1 and holds when it is 0. The count wraps modulo 2^SW.
- R3: `alarm_o` is 1 for the cycle after any edge at which the three copy states were not all equal, and 0 otherwise. `repair_o` is 1 whenever `alarm_o` is 1.
- R4: `minority_o` reports the odd copy: 0, 1 or 2 is the index of the single copy that differs from the other two, and 3 means all three differ. It is 0 while `alarm_o` is 0.
- R5: At the edge that raises `alarm_o`, all three copies are loaded with the voted state plus `adv_i`. If no new upset arrives, the alarm is low again one cycle later.
- R6: An upset that arrives on the same edge as a repair load is applied after the load. It is reported by the alarm on the next cycle, with its own minority index.
- R7: When all three copies differ, `fatal_o` becomes 1 and stays 1 until reset, and `repair_o` stays 1 for as long as `fatal_o` is 1.
- R8: A synchronous active-high `rst_i` clears all copy states and all outputs to 0.
- R9: Bits of `upset_i[k*SW +: SW]` are XOR-ed into copy k's state at the edge where they are present, after the advance or the repair load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| adv_i | input | 1 | Advance the controller by one step |
| upset_i | input | 3*SW | Per-copy bit-flip mask; copy k uses bits [k*SW +: SW] |
| data_o | output | SW | Voted controller state, registered |
| alarm_o | output | 1 | Copies disagreed on the previous cycle |
| minority_o | output | 2 | Index of the odd copy, 3 when all differ |
| fatal_o | output | 1 | Sticky: all three copies differed |
| repair_o | output | 1 | Repair request: copies were resynchronized, or fatal state |

## Verification
A repair load and a fresh upset can fall on the same clock edge. This tests whether the reload overwrites the new fault or lets it through to be caught again. The bench provokes this in its vector table by upsetting copy 2 and, on the very edge where the repair for it happens, upsetting copy 0. It then expects the voted value to track the repaired count, the alarm to stay high for one more cycle, and the reported minority to move from 2 to 0 before the alarm drops.

// File: rtl/tmr_guard_pkg.sv
package tmr_guard_pkg;
  localparam int unsigned NCOPY = 3;

  typedef enum logic [1:0] {
    ODD_C0   = 2'd0,
    ODD_C1   = 2'd1,
    ODD_C2   = 2'd2,
    ODD_NONE = 2'd3
  } odd_idx_t;
endpackage

// File: rtl/tmr_replica.sv
module tmr_replica #(
  parameter int unsigned SW = 4
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          adv_i,
  input  logic          load_en_i,
  input  logic [SW-1:0] load_val_i,
  input  logic [SW-1:0] flip_i,
  output logic [SW-1:0] state_o
);
  logic [SW-1:0] state_q;
  logic [SW-1:0] base_c;

  always_comb begin
    if (load_en_i) base_c = load_val_i;
    else           base_c = state_q + SW'(adv_i);
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) state_q <= '0;
    else       state_q <= base_c ^ flip_i;
  end

  assign state_o = state_q;
endmodule

// File: rtl/tmr_vote.sv
module tmr_vote
  import tmr_guard_pkg::*;
#(
  parameter int unsigned SW = 4
) (
  input  logic [SW-1:0] a_i,
  input  logic [SW-1:0] b_i,
  input  logic [SW-1:0] c_i,
  output logic [SW-1:0] vote_o,
  output logic          differ_o,
  output logic          alldiff_o,
  output odd_idx_t      odd_o
);
  logic eq_ab, eq_ac, eq_bc;

  assign eq_ab     = (a_i == b_i);
  assign eq_ac     = (a_i == c_i);
  assign eq_bc     = (b_i == c_i);
  assign vote_o    = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
  assign differ_o  = !(eq_ab && eq_ac);
  assign alldiff_o = !eq_ab && !eq_ac && !eq_bc;

  always_comb begin
    if (!differ_o)  odd_o = ODD_C0;
    else if (eq_bc) odd_o = ODD_C0;
    else if (eq_ac) odd_o = ODD_C1;
    else if (eq_ab) odd_o = ODD_C2;
    else            odd_o = ODD_NONE;
  end

  // R1: whenever two copies match, the vote follows them
  always_comb begin
    if (a_i == b_i) a_r1_vote_pair_ab: assert (vote_o == a_i);
    if (b_i == c_i) a_r1_vote_pair_bc: assert (vote_o == b_i);
  end
endmodule

// File: rtl/tmr_scrub_guard.sv
module tmr_scrub_guard
  import tmr_guard_pkg::*;
#(
  parameter int unsigned SW = 4
) (
  input  logic               clk_i,
  input  logic               rst_i,
  input  logic               adv_i,
  input  logic [3*SW-1:0]    upset_i,
  output logic [SW-1:0]      data_o,
  output logic               alarm_o,
  output logic [1:0]         minority_o,
  output logic               fatal_o,
  output logic               repair_o
);
  localparam int unsigned FW = NCOPY * SW;

  logic [SW-1:0] st [NCOPY];
  logic [SW-1:0] vote_c;
  logic [SW-1:0] reload_c;
  logic          differ_c;
  logic          alldiff_c;
  odd_idx_t      odd_c;

  assign reload_c = vote_c + SW'(adv_i);

  for (genvar k = 0; k < NCOPY; k++) begin : g_copy
    tmr_replica #(.SW(SW)) u_rep (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .adv_i      (adv_i),
      .load_en_i  (differ_c),
      .load_val_i (reload_c),
      .flip_i     (upset_i[k*SW +: SW]),
      .state_o    (st[k])
    );
  end

  tmr_vote #(.SW(SW)) u_vote (
    .a_i       (st[0]),
    .b_i       (st[1]),
    .c_i       (st[2]),
    .vote_o    (vote_c),
    .differ_o  (differ_c),
    .alldiff_o (alldiff_c),
    .odd_o     (odd_c)
  );

  logic [SW-1:0] data_q;
  logic          alarm_q, fatal_q, repair_q;
  logic [1:0]    odd_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      data_q   <= '0;
      alarm_q  <= 1'b0;
      odd_q    <= 2'd0;
      fatal_q  <= 1'b0;
      repair_q <= 1'b0;
    end else begin
      data_q   <= vote_c;
      alarm_q  <= differ_c;
      odd_q    <= odd_c;
      fatal_q  <= fatal_q | alldiff_c;
      repair_q <= differ_c | alldiff_c | fatal_q;
    end
  end

  assign data_o     = data_q;
  assign alarm_o    = alarm_q;
  assign minority_o = odd_q;
  assign fatal_o    = fatal_q;
  assign repair_o   = repair_q;

  // R5: a repair with no fresh upset leaves the copies in agreement
  a_r5_repair_resyncs: assert property (@(posedge clk_i) disable iff (rst_i)
    (differ_c && upset_i == '0) |=> !differ_c);

  // R7: the fatal flag holds until reset
  a_r7_fatal_sticky: assert property (@(posedge clk_i) disable iff (rst_i)
    fatal_o |=> fatal_o);

  // R7: repair request held while fatal
  a_r7_repair_held: assert property (@(posedge clk_i) disable iff (rst_i)
    fatal_o |-> repair_o);

  // R3: alarm always comes with a repair request
  a_r3_alarm_repair: assert property (@(posedge clk_i) disable iff (rst_i)
    alarm_o |-> repair_o);

  // R4: index is quiet without an alarm
  a_r4_quiet_index: assert property (@(posedge clk_i) disable iff (rst_i)
    !alarm_o |-> minority_o == 2'd0);

  // R8: the cycle after a reset edge shows a clean output
  a_r8_reset_clears: assert property (@(posedge clk_i)
    rst_i |=> (data_o == '0 && !alarm_o && !fatal_o && !repair_o));
endmodule

// File: tb/tb_tmr_scrub_guard.sv
`timescale 1ns/1ps
module tb_tmr_scrub_guard;
  localparam int SW = 4;
  localparam int NV = 11;

  logic          clk = 1'b0;
  logic          rst_i;
  logic          adv_i;
  logic [3*SW-1:0] upset_i;
  logic [SW-1:0] data_o;
  logic          alarm_o;
  logic [1:0]    minority_o;
  logic          fatal_o;
  logic          repair_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tmr_scrub_guard #(.SW(SW)) dut (
    .clk_i(clk), .rst_i(rst_i), .adv_i(adv_i), .upset_i(upset_i),
    .data_o(data_o), .alarm_o(alarm_o), .minority_o(minority_o),
    .fatal_o(fatal_o), .repair_o(repair_o)
  );

  // stimulus {adv, flip c0, flip c1, flip c2}, expected after the edge
  // {data, alarm, minority, fatal, repair}
  localparam logic [21:0] TBL [NV] = '{
    {1'b1, 4'h0, 4'h0, 4'h0,  4'd0, 1'b0, 2'd0, 1'b0, 1'b0},
    {1'b1, 4'h0, 4'h1, 4'h0,  4'd1, 1'b0, 2'd0, 1'b0, 1'b0},
    {1'b0, 4'h0, 4'h0, 4'h0,  4'd2, 1'b1, 2'd1, 1'b0, 1'b1},
    {1'b0, 4'h0, 4'h0, 4'h0,  4'd2, 1'b0, 2'd0, 1'b0, 1'b0},
    {1'b1, 4'h0, 4'h0, 4'h4,  4'd2, 1'b0, 2'd0, 1'b0, 1'b0},
    {1'b1, 4'h8, 4'h0, 4'h0,  4'd3, 1'b1, 2'd2, 1'b0, 1'b1},
    {1'b0, 4'h0, 4'h0, 4'h0,  4'd4, 1'b1, 2'd0, 1'b0, 1'b1},
    {1'b1, 4'h0, 4'h0, 4'h0,  4'd4, 1'b0, 2'd0, 1'b0, 1'b0},
    {1'b1, 4'h1, 4'h2, 4'h0,  4'd5, 1'b0, 2'd0, 1'b0, 1'b0},
    {1'b0, 4'h0, 4'h0, 4'h0,  4'd6, 1'b1, 2'd3, 1'b1, 1'b1},
    {1'b1, 4'h0, 4'h0, 4'h0,  4'd6, 1'b0, 2'd0, 1'b1, 1'b1}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_i = 1'b1; adv_i = 1'b0; upset_i = '0;
    repeat (3) tick();
    chk("R8 reset data", int'(data_o), 0);
    chk("R8 reset alarm", int'(alarm_o), 0);
    chk("R8 reset fatal", int'(fatal_o), 0);
    rst_i = 1'b0;

    for (int i = 0; i < NV; i++) begin
      adv_i   = TBL[i][21];
      upset_i = {TBL[i][12:9], TBL[i][16:13], TBL[i][20:17]};
      tick();
      chk($sformatf("R1/R2/R6/R9 row%0d data", i), int'(data_o), int'(TBL[i][8:5]));
      chk($sformatf("R3/R5 row%0d alarm", i), int'(alarm_o), int'(TBL[i][4]));
      chk($sformatf("R4 row%0d minority", i), int'(minority_o), int'(TBL[i][3:2]));
      chk($sformatf("R7 row%0d fatal", i), int'(fatal_o), int'(TBL[i][1]));
      chk($sformatf("R3/R7 row%0d repair", i), int'(repair_o), int'(TBL[i][0]));
    end
    adv_i = 1'b0; upset_i = '0;

    // R7: fatal still held several cycles later; R8 clears it
    repeat (3) tick();
    chk("R7 fatal sticky", int'(fatal_o), 1);
    chk("R7 repair held", int'(repair_o), 1);
    rst_i = 1'b1;
    tick();
    rst_i = 1'b0;
    chk("R8 mid-run reset fatal", int'(fatal_o), 0);
    chk("R8 mid-run reset repair", int'(repair_o), 0);
    chk("R8 mid-run reset data", int'(data_o), 0);

    // R2: sixteen advances wrap the count
    adv_i = 1'b1;
    repeat (16) tick();
    chk("R2 count at top", int'(data_o), 15);
    tick();
    adv_i = 1'b0;
    chk("R2 wrap to zero", int'(data_o), 0);
    chk("R2 no alarm on wrap", int'(alarm_o), 0);

    // R5/R9: single upset on copy 0, alarm for exactly one cycle
    upset_i = {4'h0, 4'h0, 4'h2};
    tick();
    upset_i = '0;
    tick();
    chk("R5 alarm raised", int'(alarm_o), 1);
    chk("R4 copy0 odd", int'(minority_o), 0);
    chk("R1 masked data", int'(data_o), 1);
    tick();
    chk("R5 alarm cleared", int'(alarm_o), 0);
    chk("R5 repaired data", int'(data_o), 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    done = 1'b1;
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule